// File: doc/BRIEF.md
# Register frame descriptor update unit

This unit keeps three pieces of architectural state for a stacked register file: the current frame marker, the caller-state register that a procedure call fills, and the pointer to the top of the frame region in the memory backing store. The frame marker holds the frame size, the size of the local part, the size of the rotating region and three rotating-rename bases. The caller-state register holds a saved frame marker, an epilog count and a privilege level.

Each clock cycle at most one instruction event arrives on `ev_code`: allocate, call, return or interruption-return. The unit computes every new register value for that event and commits all of them on the same clock edge. The pointer moves in 8-byte slots, and its low six slot bits select a position inside a 64-slot group. Slot 63 of each group is reserved, so a pointer step skips one extra slot for every 63 registers it crosses. This holds in both directions. Memory traffic and incomplete frames are handled elsewhere.

Top module: `frame_desc_unit`

## Requirements
- R1: While `rst_n` is low, `frame_q` and `caller_q` are zero, `stack_ptr_q` equals the parameter `PTR_RST` (default 0x1000) and `alloc_dest_wr` is 0.
- R2: Event code 1 (allocate) makes the frame size `alloc_in+alloc_loc+alloc_out` (mod 128), the local size `alloc_in+alloc_loc` and the rotating size `alloc_rot>>3`. It keeps the rename bases, the pointer and `caller_q`. Frame marker layout: size [6:0], locals [13:7], rotating [17:14], integer rename [24:18], float rename [31:25], predicate rename [37:32].
- R3: In the cycle after an allocate, `alloc_dest_wr` is 1 and `alloc_dest` holds the `caller_q` value from before the event. After any other event, `alloc_dest_wr` is 0.
- R4: Event code 2 (call) advances the pointer by L + (s+L)/63 slots, where L is the current local size, s is `stack_ptr_q[8:3]` and the division is an integer division.
- R5: A call loads `caller_q` with the current frame marker in [37:0], `epilog_cnt` in [43:38] and `priv_lvl` in [45:44]. The new frame size is the old size minus the old local size, and every other marker field becomes zero.
- R6: Event code 3 (return) moves the pointer back by L + (62-s+L)/63 slots, where L is the local size saved in `caller_q`. It copies the saved marker into `frame_q`. A return right after a call puts the pointer back where it was before the call.
- R7: A return with `caller_bad` high moves the pointer as in R6, but sets `frame_q` to all zero.
- R8: Event code 4 (interruption-return) with `irq_frame_valid` high moves the pointer back by F + (62-s+F)/63 slots, where F is the frame size of `irq_frame`. It loads `irq_frame` into `frame_q`.
- R9: An interruption-return with `irq_frame_valid` low, code 0, and the unused codes 5 to 7 leave `frame_q`, `caller_q` and `stack_ptr_q` unchanged.
- R10: Bits 2:0 of `stack_ptr_q` never change after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_code | input | 3 | Event: 0 none, 1 allocate, 2 call, 3 return, 4 interruption-return |
| alloc_in | input | 7 | Allocate input-register count |
| alloc_loc | input | 7 | Allocate local-register count |
| alloc_out | input | 7 | Allocate output-register count |
| alloc_rot | input | 7 | Allocate rotating-register count |
| epilog_cnt | input | 6 | Epilog count that a call saves |
| priv_lvl | input | 2 | Current privilege level that a call saves |
| irq_frame_valid | input | 1 | The saved interruption frame is valid |
| irq_frame | input | 38 | Saved interruption frame marker |
| caller_bad | input | 1 | The caller state read by a return is bad |
| frame_q | output | 38 | Current frame marker |
| caller_q | output | 46 | Caller-state register |
| stack_ptr_q | output | 64 | Backing-store frame pointer |
| alloc_dest | output | 46 | Old caller state returned to the allocate destination |
| alloc_dest_wr | output | 1 | Write strobe for `alloc_dest` |

## Verification
The assertions check on every cycle the properties that need no arithmetic model. An allocate keeps the pointer and produces the destination strobe with the old caller state. A call saves the old marker and clears the local size, and it moves the pointer forward by a slot count between L and L+3. A return restores the saved marker, or clears it when the saved state is bad. Idle and invalid events hold all state, and the pointer's byte offset never changes. Only the bench scenarios can show the exact slot counts at group boundaries, the return-after-call round trip, and the exact field packing of allocate results and caller saves.

// File: rtl/fdu_pkg.sv
package fdu_pkg;
    localparam int SZ_W   = 7;
    localparam int ROT_W  = 4;
    localparam int RGR_W  = 7;
    localparam int RFR_W  = 7;
    localparam int RPR_W  = 6;
    localparam int EPI_W  = 6;
    localparam int PRV_W  = 2;
    localparam int PTR_W  = 64;
    localparam int SLOT_W = 6;
    localparam int EV_W   = 3;
    localparam int ROT_SHIFT = 3;

    typedef struct packed {
        logic [RPR_W-1:0] ren_prd;
        logic [RFR_W-1:0] ren_flt;
        logic [RGR_W-1:0] ren_int;
        logic [ROT_W-1:0] rot;
        logic [SZ_W-1:0]  locals;
        logic [SZ_W-1:0]  size;
    } frame_mark_t;

    localparam int MARK_W = $bits(frame_mark_t);

    typedef struct packed {
        logic [PRV_W-1:0] priv;
        logic [EPI_W-1:0] epilog;
        frame_mark_t      mark;
    } caller_t;

    localparam int CALLER_W = $bits(caller_t);

    typedef struct packed {
        frame_mark_t      mark;
        caller_t          caller;
        logic [PTR_W-1:0] ptr;
        caller_t          dest;
        logic             dest_wr;
    } fdu_state_t;

    typedef enum logic [EV_W-1:0] {
        EV_NONE  = 3'd0,
        EV_ALLOC = 3'd1,
        EV_CALL  = 3'd2,
        EV_RET   = 3'd3,
        EV_IRET  = 3'd4
    } fdu_ev_e;
endpackage

// File: rtl/fdu_ptr_step.sv
// Moves a slot pointer by a count of registers and skips the reserved
// slot that ends each 64-slot group. RETREAT picks the direction.
module fdu_ptr_step #(
    parameter int PTR_W   = 64,
    parameter int CNT_W   = 7,
    parameter int SLOT_W  = 6,
    parameter bit RETREAT = 1'b0
)(
    input  logic [PTR_W-1:0] ptr_in,
    input  logic [CNT_W-1:0] count,
    output logic [PTR_W-1:0] ptr_out
);
    localparam int GRP   = (1 << SLOT_W) - 1;
    localparam int SUM_W = CNT_W + SLOT_W + 1;
    localparam int HI_W  = PTR_W - 3;

    logic [SLOT_W-1:0] slot;
    logic [HI_W-1:0]   hi;
    logic [HI_W-1:0]   hi_next;
    logic [SUM_W-1:0]  span;
    logic [SUM_W-1:0]  extra;

    assign slot = ptr_in[SLOT_W+2:3];
    assign hi   = ptr_in[PTR_W-1:3];

    generate
        if (RETREAT) begin : g_back
            logic [SUM_W-1:0] head;
            assign head    = SUM_W'(GRP - 1) + SUM_W'(count);
            // slot 63 with a zero count would go negative: no skip then
            assign span    = (head >= SUM_W'(slot)) ? head - SUM_W'(slot) : '0;
            assign extra   = span / SUM_W'(GRP);
            assign hi_next = hi - HI_W'(count) - HI_W'(extra);
        end else begin : g_fwd
            assign span    = SUM_W'(slot) + SUM_W'(count);
            assign extra   = span / SUM_W'(GRP);
            assign hi_next = hi + HI_W'(count) + HI_W'(extra);
        end
    endgenerate

    assign ptr_out = {hi_next, ptr_in[2:0]};
endmodule

// File: rtl/fdu_alloc_decode.sv
// Builds the frame marker that an allocate produces from its operands.
module fdu_alloc_decode
    import fdu_pkg::*;
(
    input  logic [SZ_W-1:0] n_in,
    input  logic [SZ_W-1:0] n_loc,
    input  logic [SZ_W-1:0] n_out,
    input  logic [SZ_W-1:0] n_rot,
    input  frame_mark_t     cur_mark,
    output frame_mark_t     new_mark
);
    always_comb begin
        new_mark        = cur_mark;
        new_mark.size   = n_in + n_loc + n_out;
        new_mark.locals = n_in + n_loc;
        new_mark.rot    = ROT_W'(n_rot >> ROT_SHIFT);
    end
endmodule

// File: rtl/frame_desc_unit.sv
module frame_desc_unit
    import fdu_pkg::*;
#(
    parameter logic [PTR_W-1:0] PTR_RST = PTR_W'(4096)
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [EV_W-1:0]     ev_code,
    input  logic [SZ_W-1:0]     alloc_in,
    input  logic [SZ_W-1:0]     alloc_loc,
    input  logic [SZ_W-1:0]     alloc_out,
    input  logic [SZ_W-1:0]     alloc_rot,
    input  logic [EPI_W-1:0]    epilog_cnt,
    input  logic [PRV_W-1:0]    priv_lvl,
    input  logic                irq_frame_valid,
    input  logic [MARK_W-1:0]   irq_frame,
    input  logic                caller_bad,
    output logic [MARK_W-1:0]   frame_q,
    output logic [CALLER_W-1:0] caller_q,
    output logic [PTR_W-1:0]    stack_ptr_q,
    output logic [CALLER_W-1:0] alloc_dest,
    output logic                alloc_dest_wr
);
    fdu_state_t  st_q;
    fdu_state_t  st_d;
    frame_mark_t irq_mark;
    frame_mark_t alloc_mark;
    logic [PTR_W-1:0] ptr_call;
    logic [PTR_W-1:0] ptr_ret;
    logic [PTR_W-1:0] ptr_iret;

    assign irq_mark = frame_mark_t'(irq_frame);

    fdu_alloc_decode u_alloc (
        .n_in     (alloc_in),
        .n_loc    (alloc_loc),
        .n_out    (alloc_out),
        .n_rot    (alloc_rot),
        .cur_mark (st_q.mark),
        .new_mark (alloc_mark)
    );

    // call: forward by the current local size
    fdu_ptr_step #(.PTR_W(PTR_W), .CNT_W(SZ_W), .SLOT_W(SLOT_W), .RETREAT(1'b0)) u_step_call (
        .ptr_in  (st_q.ptr),
        .count   (st_q.mark.locals),
        .ptr_out (ptr_call)
    );

    // return: back by the local size kept in the caller state
    fdu_ptr_step #(.PTR_W(PTR_W), .CNT_W(SZ_W), .SLOT_W(SLOT_W), .RETREAT(1'b1)) u_step_ret (
        .ptr_in  (st_q.ptr),
        .count   (st_q.caller.mark.locals),
        .ptr_out (ptr_ret)
    );

    // interruption-return: back by the saved frame size
    fdu_ptr_step #(.PTR_W(PTR_W), .CNT_W(SZ_W), .SLOT_W(SLOT_W), .RETREAT(1'b1)) u_step_iret (
        .ptr_in  (st_q.ptr),
        .count   (irq_mark.size),
        .ptr_out (ptr_iret)
    );

    always_comb begin
        st_d         = st_q;
        st_d.dest_wr = 1'b0;
        case (ev_code)
            EV_ALLOC: begin
                st_d.mark    = alloc_mark;
                st_d.dest    = st_q.caller;
                st_d.dest_wr = 1'b1;
            end
            EV_CALL: begin
                st_d.ptr           = ptr_call;
                st_d.caller.priv   = priv_lvl;
                st_d.caller.epilog = epilog_cnt;
                st_d.caller.mark   = st_q.mark;
                st_d.mark          = '0;
                st_d.mark.size     = st_q.mark.size - st_q.mark.locals;
            end
            EV_RET: begin
                st_d.ptr  = ptr_ret;
                st_d.mark = caller_bad ? frame_mark_t'('0) : st_q.caller.mark;
            end
            EV_IRET: begin
                if (irq_frame_valid) begin
                    st_d.ptr  = ptr_iret;
                    st_d.mark = irq_mark;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mark    <= '0;
            st_q.caller  <= '0;
            st_q.ptr     <= PTR_RST;
            st_q.dest    <= '0;
            st_q.dest_wr <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_q       = st_q.mark;
    assign caller_q      = st_q.caller;
    assign stack_ptr_q   = st_q.ptr;
    assign alloc_dest    = st_q.dest;
    assign alloc_dest_wr = st_q.dest_wr;
endmodule

// File: rtl/fdu_checker.sv
module fdu_checker
    import fdu_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic [EV_W-1:0]     ev_code,
    input logic                caller_bad,
    input logic                irq_frame_valid,
    input logic [MARK_W-1:0]   frame_q,
    input logic [CALLER_W-1:0] caller_q,
    input logic [PTR_W-1:0]    stack_ptr_q,
    input logic [CALLER_W-1:0] alloc_dest,
    input logic                alloc_dest_wr
);
    frame_mark_t fm;
    assign fm = frame_mark_t'(frame_q);

    logic hold_ev;
    assign hold_ev = (ev_code == EV_IRET && !irq_frame_valid) || ev_code == EV_NONE
                   || ev_code > EV_IRET;

    assert_alloc_ptr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_code == EV_ALLOC) |=> $stable(stack_ptr_q) && $stable(caller_q));

    assert_alloc_dest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_code == EV_ALLOC) |=> alloc_dest_wr && alloc_dest == $past(caller_q));

    assert_dest_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_code != EV_ALLOC) |=> !alloc_dest_wr);

    assert_call_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_code == EV_CALL) |=>
            (((stack_ptr_q - $past(stack_ptr_q)) >> 3) >= PTR_W'($past(fm.locals))) &&
            (((stack_ptr_q - $past(stack_ptr_q)) >> 3) <= PTR_W'($past(fm.locals)) + PTR_W'(3)));

    assert_call_save_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_code == EV_CALL) |=>
            caller_q[MARK_W-1:0] == $past(frame_q) && fm.locals == '0 && fm.rot == '0);

    assert_ret_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_code == EV_RET && !caller_bad) |=> frame_q == $past(caller_q[MARK_W-1:0]));

    assert_bad_ret_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_code == EV_RET && caller_bad) |=> frame_q == '0);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ev |=> $stable(frame_q) && $stable(stack_ptr_q) && $stable(caller_q));

    assert_low_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(stack_ptr_q[2:0]));
endmodule

bind frame_desc_unit fdu_checker u_fdu_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .ev_code         (ev_code),
    .caller_bad      (caller_bad),
    .irq_frame_valid (irq_frame_valid),
    .frame_q         (frame_q),
    .caller_q        (caller_q),
    .stack_ptr_q     (stack_ptr_q),
    .alloc_dest      (alloc_dest),
    .alloc_dest_wr   (alloc_dest_wr)
);

// File: tb/frame_desc_unit_bench.sv
`timescale 1ns/1ps
module frame_desc_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ev_code = '0;
    logic [6:0]  alloc_in = '0, alloc_loc = '0, alloc_out = '0, alloc_rot = '0;
    logic [5:0]  epilog_cnt = '0;
    logic [1:0]  priv_lvl = '0;
    logic        irq_frame_valid = 1'b0;
    logic [37:0] irq_frame = '0;
    logic        caller_bad = 1'b0;
    logic [37:0] frame_q;
    logic [45:0] caller_q;
    logic [63:0] stack_ptr_q;
    logic [45:0] alloc_dest;
    logic        alloc_dest_wr;

    int n_chk = 0;
    int n_bad = 0;
    logic [37:0] m_mark;
    logic [45:0] m_caller;
    logic [63:0] m_ptr;

    always #2 clk = ~clk;

    frame_desc_unit u_frame_desc_unit (
        .clk(clk), .rst_n(rst_n), .ev_code(ev_code),
        .alloc_in(alloc_in), .alloc_loc(alloc_loc), .alloc_out(alloc_out), .alloc_rot(alloc_rot),
        .epilog_cnt(epilog_cnt), .priv_lvl(priv_lvl),
        .irq_frame_valid(irq_frame_valid), .irq_frame(irq_frame), .caller_bad(caller_bad),
        .frame_q(frame_q), .caller_q(caller_q), .stack_ptr_q(stack_ptr_q),
        .alloc_dest(alloc_dest), .alloc_dest_wr(alloc_dest_wr)
    );

    function automatic logic [37:0] mk(int sz, int lc, int rt, int gr, int fr, int pr);
        return {6'(pr), 7'(fr), 7'(gr), 4'(rt), 7'(lc), 7'(sz)};
    endfunction

    function automatic logic [63:0] f_fwd(logic [63:0] p, int n);
        int slot = int'(p[8:3]);
        return p + 64'((n + (slot + n) / 63) * 8);
    endfunction

    function automatic logic [63:0] f_back(logic [63:0] p, int n);
        int slot = int'(p[8:3]);
        int t = 62 - slot + n;
        if (t < 0) t = 0;
        return p - 64'((n + t / 63) * 8);
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_state(string req);
        chk(req, "frame", 64'(frame_q), 64'(m_mark));
        chk(req, "caller", 64'(caller_q), 64'(m_caller));
        chk(req, "pointer", stack_ptr_q, m_ptr);
        chk("R10", "pointer low bits", 64'(stack_ptr_q[2:0]), 64'd0);
    endtask

    task automatic fire(logic [2:0] code);
        @(negedge clk);
        ev_code = code;
        @(negedge clk);
        ev_code = 3'd0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        m_mark = '0; m_caller = '0; m_ptr = 64'h1000;
        chk_state("R1");
        chk("R1", "dest strobe", 64'(alloc_dest_wr), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_state("R1");
    endtask

    task automatic t_alloc(int i, int l, int o, int r);
        logic [45:0] old_caller = m_caller;
        alloc_in = 7'(i); alloc_loc = 7'(l); alloc_out = 7'(o); alloc_rot = 7'(r);
        fire(3'd1);
        m_mark = mk(i + l + o, i + l, r / 8, int'(m_mark[24:18]), int'(m_mark[31:25]),
                    int'(m_mark[37:32]));
        chk_state("R2");
        chk("R3", "dest strobe", 64'(alloc_dest_wr), 64'd1);
        chk("R3", "dest value", 64'(alloc_dest), 64'(old_caller));
        @(negedge clk);
        chk("R3", "dest strobe idle", 64'(alloc_dest_wr), 64'd0);
    endtask

    task automatic t_call(int epi, int prv);
        epilog_cnt = 6'(epi); priv_lvl = 2'(prv);
        fire(3'd2);
        m_ptr = f_fwd(m_ptr, int'(m_mark[13:7]));
        m_caller = {2'(prv), 6'(epi), m_mark};
        m_mark = mk(int'(m_mark[6:0]) - int'(m_mark[13:7]), 0, 0, 0, 0, 0);
        chk_state("R4");
        chk("R5", "caller save", 64'(caller_q), 64'(m_caller));
        chk("R3", "dest strobe after call", 64'(alloc_dest_wr), 64'd0);
    endtask

    task automatic t_ret(bit bad, logic [63:0] before_call);
        caller_bad = bad;
        fire(3'd3);
        caller_bad = 1'b0;
        m_ptr = f_back(m_ptr, int'(m_caller[13:7]));
        m_mark = bad ? 38'd0 : m_caller[37:0];
        chk_state(bad ? "R7" : "R6");
        chk("R6", "round trip pointer", stack_ptr_q, before_call);
    endtask

    task automatic t_iret(bit vld, logic [37:0] fr);
        irq_frame_valid = vld; irq_frame = fr;
        fire(3'd4);
        irq_frame_valid = 1'b0;
        if (vld) begin
            m_ptr = f_back(m_ptr, int'(fr[6:0]));
            m_mark = fr;
        end
        chk_state(vld ? "R8" : "R9");
    endtask

    task automatic t_idle(logic [2:0] code);
        caller_bad = 1'b1; irq_frame = '1;
        fire(code);
        caller_bad = 1'b0; irq_frame = '0;
        chk_state("R9");
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] p0;
        t_reset();
        t_iret(1'b1, mk(30, 20, 2, 5, 9, 3));   // R8: 31 slots back, renames nonzero
        t_alloc(8, 4, 3, 16);                   // R2: renames kept
        p0 = m_ptr;
        t_call(42, 3);                          // R4/R5 no group crossing
        t_ret(1'b0, p0);                        // R6
        t_alloc(0, 60, 2, 96);                  // R3: old caller comes back
        p0 = m_ptr;
        t_call(7, 1);                           // R4: crosses a group end
        t_ret(1'b0, p0);
        p0 = m_ptr;
        t_call(1, 2);
        t_ret(1'b1, p0);                        // R7
        t_iret(1'b0, mk(50, 10, 1, 1, 1, 1));   // R9
        t_idle(3'd0);
        t_idle(3'd5);
        t_idle(3'd7);
        t_iret(1'b1, mk(0, 0, 0, 0, 0, 0));     // R8 zero-size frame
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule